// File: doc/BRIEF.md
# Instruction Cycle State Sequencer

This block is the control sequencer of a small processor. It steps through the instruction cycle in a fixed series of phases:

- work out the next instruction address;
- fetch the instruction word into an instruction register;
- decode it;
- work out and fetch the operands;
- run the data operation;
- work out the result address and write the result.

Every phase is reported on a one-hot phase vector, and the datapath uses those bits as its enables. A combinational decoder outside the block looks at the instruction register. It returns an operation class, read and write flags, a return flag, an element count and two address fields. The sequencer picks its path from these values.

Memory and I/O share one synchronous request port. A request waits in place until the port signals ready. Operations on vectors and strings run the operand phases once for each element. The last phase of every instruction checks for an interrupt. When an interrupt is taken, the sequencer saves the resume address in a shadow register and redirects the fetch to a handler address. While the handler runs, further requests are held off, and a return instruction restores the saved address.

Top module: `icycle_seq`

## Requirements
- R1: A synchronous active-high reset puts the sequencer in the address phase with the program counter at zero, so the first fetch after reset reads address 0.
- R2: `phase` is one-hot with bit 0 address calculation, 1 fetch, 2 decode, 3 operand address, 4 operand fetch, 5 data operation, 6 store, 7 interrupt check. Each internal phase (0, 2, 3, 5, 7) lasts exactly one clock.
- R3: A fetch, operand fetch or store phase keeps `mem_req` high and holds its address until `mem_rdy` is sampled high.
- R4: The next instruction address is the previous one plus `INC`. A control-class instruction (`dec_cls` = 11) that is not a return instead sets the next address to `dec_src`, and it skips all operand phases.
- R5: The fetch reads the address held in the program counter, and the word it returns is presented on `instr`.
- R6: An operand fetch reads `dec_src + index`, after an operand address phase. A store writes `dec_dst + index`, after a second operand address phase. A memory or I/O transfer (`dec_cls` 00 or 01) skips the data operation and stores the fetched operand. Data processing (`dec_cls` 10) spends one data operation clock and stores `dp_result`.
- R7: When `dec_rd` or `dec_wr` is set, the operand phases repeat for `dec_cnt + 1` elements, with the index running from 0.
- R8: `io_sel` is high during the operand fetch and store of an I/O-class instruction (`dec_cls` = 01) and low for memory-class instructions.
- R9: In the interrupt-check phase, an `irq` that is not masked raises `irq_ack` for that clock. It saves the address the program would have run next, and the next fetch reads address `HANDLER`.
- R10: After an interrupt is taken, `irq` is ignored until a return has been processed, and a request that is still held is taken at the end of the next instruction.
- R11: A control-class instruction with `dec_ret` set makes the next address calculation load the saved address, and it removes the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_req | output | 1 | Memory/I/O request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Request address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid with `mem_rdy` |
| mem_rdy | input | 1 | Request completes this clock |
| io_sel | output | 1 | Request targets I/O space |
| instr | output | DW | Instruction register |
| dec_cls | input | 2 | Operation class: 00 memory, 01 I/O, 10 data processing, 11 control |
| dec_rd | input | 1 | Instruction reads operands |
| dec_wr | input | 1 | Instruction stores a result |
| dec_ret | input | 1 | Control instruction is a return |
| dec_cnt | input | CW | Element count minus one |
| dec_src | input | AW | Operand base address, or jump target |
| dec_dst | input | AW | Result base address |
| opnd_data | output | DW | Last fetched operand |
| dp_result | input | DW | Datapath result to store |
| irq | input | 1 | Interrupt request, level |
| irq_ack | output | 1 | Interrupt accepted this clock |
| phase | output | 8 | One-hot phase vector |

## Verification
Two things can land in the same interrupt-check phase: a held request, and the end of a return instruction that is about to remove the mask. Jump redirection and context save can also meet in one cycle, when a jump ends right as an interrupt is accepted. The bench spins on a jump-to-self, raises `irq` once the spin begins, and keeps it high through the whole handler. The expected fetch order shows whether these cases were resolved correctly. The handler address must follow the jump instruction. The handler's second instruction must follow its first, with no re-entry. After the return, the spin address must be fetched exactly once before the handler is entered a second time.

// File: rtl/icycle_seq.sv
module icycle_seq #(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter int CW = 3,
  parameter int INC = 1,
  parameter int HANDLER = 240
) (
  input  logic          clk,
  input  logic          rst,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_rdy,
  output logic          io_sel,
  output logic [DW-1:0] instr,
  input  logic [1:0]    dec_cls,
  input  logic          dec_rd,
  input  logic          dec_wr,
  input  logic          dec_ret,
  input  logic [CW-1:0] dec_cnt,
  input  logic [AW-1:0] dec_src,
  input  logic [AW-1:0] dec_dst,
  output logic [DW-1:0] opnd_data,
  input  logic [DW-1:0] dp_result,
  input  logic          irq,
  output logic          irq_ack,
  output logic [7:0]    phase
);
  typedef enum logic [2:0] {S_IAC, S_IF, S_IOD, S_OAC, S_OF, S_DO, S_OS, S_INT} st_t;

  st_t st, nx;
  logic nx_store, st_store, adv;
  logic [AW-1:0] pc, oaddr, shadow, tgt;
  logic [CW-1:0] idx;
  logic redir, ret_pend, in_hdl;

  wire last = (idx == dec_cnt) || !(dec_rd || dec_wr);
  wire take = irq && !in_hdl;
  wire [AW-1:0] seq_pc = pc + AW'(INC);

  always_comb begin
    nx = st;
    nx_store = 1'b0;
    adv = 1'b0;
    case (st)
      S_IAC: nx = S_IF;
      S_IF:  if (mem_rdy) nx = S_IOD;
      S_IOD: begin
        if (dec_cls == 2'b11) nx = S_INT;
        else if (dec_rd) nx = S_OAC;
        else if (dec_cls == 2'b10) nx = S_DO;
        else if (dec_wr) begin nx = S_OAC; nx_store = 1'b1; end
        else nx = S_INT;
      end
      S_OAC: nx = st_store ? S_OS : S_OF;
      S_OF: if (mem_rdy) begin
        if (dec_cls == 2'b10) nx = S_DO;
        else if (dec_wr) begin nx = S_OAC; nx_store = 1'b1; end
        else begin nx = last ? S_INT : S_OAC; adv = !last; end
      end
      S_DO: begin
        if (dec_wr) begin nx = S_OAC; nx_store = 1'b1; end
        else begin nx = last ? S_INT : S_OAC; adv = !last; end
      end
      S_OS: if (mem_rdy) begin
        nx = last ? S_INT : S_OAC;
        nx_store = !dec_rd;
        adv = !last;
      end
      S_INT: nx = S_IAC;
      default: nx = S_IAC;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IAC;
      st_store <= 1'b0;
      pc <= '0;
      tgt <= '0;
      redir <= 1'b1;
      ret_pend <= 1'b0;
      in_hdl <= 1'b0;
      shadow <= '0;
      oaddr <= '0;
      idx <= '0;
      instr <= '0;
      opnd_data <= '0;
    end else begin
      st <= nx;
      if (nx == S_OAC) st_store <= nx_store;
      if (adv) idx <= idx + 1'b1;
      case (st)
        S_IAC: begin
          pc <= ret_pend ? shadow : (redir ? tgt : seq_pc);
          redir <= 1'b0;
          ret_pend <= 1'b0;
          if (ret_pend) in_hdl <= 1'b0;
        end
        S_IF: if (mem_rdy) instr <= mem_rdata;
        S_IOD: begin
          idx <= '0;
          if (dec_cls == 2'b11) begin
            if (dec_ret) ret_pend <= 1'b1;
            else begin redir <= 1'b1; tgt <= dec_src; end
          end
        end
        S_OAC: oaddr <= (st_store ? dec_dst : dec_src) + AW'(idx);
        S_OF: if (mem_rdy) opnd_data <= mem_rdata;
        S_INT: if (take) begin
          shadow <= redir ? tgt : seq_pc;
          redir <= 1'b1;
          tgt <= AW'(HANDLER);
          in_hdl <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign phase = 8'(1) << st;
  assign mem_req = (st == S_IF) || (st == S_OF) || (st == S_OS);
  assign mem_we = (st == S_OS);
  assign mem_addr = (st == S_IF) ? pc : oaddr;
  assign mem_wdata = (dec_cls == 2'b10) ? dp_result : opnd_data;
  assign io_sel = (dec_cls == 2'b01) && ((st == S_OF) || (st == S_OS));
  assign irq_ack = (st == S_INT) && take;

  // R3
  mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_rdy |=> mem_req && $stable(mem_addr) && $stable(phase));
  // R2
  do_single_chk: assert property (@(posedge clk) disable iff (rst)
    phase[5] |=> !phase[5]);
  // R2
  iac_single_chk: assert property (@(posedge clk) disable iff (rst)
    phase[0] |=> phase[1]);
  // R9
  ack_valid_chk: assert property (@(posedge clk) disable iff (rst)
    irq_ack |-> irq && phase[7]);
  // R9
  handler_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    irq_ack |=> ##1 (mem_req && !mem_we && mem_addr == AW'(HANDLER)));
endmodule

// File: tb/icycle_seq_test.sv
module icycle_seq_test;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [7:0]  a;
    logic        we;
    logic [15:0] d;
    logic        io;
    int          gap;
    string       tag;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mem_req, mem_we, mem_rdy, io_sel, irq_ack;
  logic [7:0] mem_addr, dec_src, dec_dst;
  logic [15:0] mem_wdata, mem_rdata, instr, opnd_data, dp_result;
  logic [1:0] dec_cls;
  logic dec_rd, dec_wr, dec_ret;
  logic [2:0] dec_cnt;
  logic [7:0] phase;
  logic irq = 1'b0;

  logic [15:0] mem [256];
  item_t q[$];
  int checks = 0, failures = 0, cyc = 0, last_hs = 0, acks = 0, wcnt = 0;
  bit done = 0, raised = 0, drop_pend = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  icycle_seq uut (
    .clk(clk), .rst(rst), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rdy(mem_rdy), .io_sel(io_sel),
    .instr(instr), .dec_cls(dec_cls), .dec_rd(dec_rd), .dec_wr(dec_wr), .dec_ret(dec_ret),
    .dec_cnt(dec_cnt), .dec_src(dec_src), .dec_dst(dec_dst), .opnd_data(opnd_data),
    .dp_result(dp_result), .irq(irq), .irq_ack(irq_ack), .phase(phase)
  );

  assign dec_cls = instr[15:14];
  assign dec_rd = instr[13];
  assign dec_wr = instr[12];
  assign dec_ret = instr[11];
  assign dec_cnt = instr[10:8];
  assign dec_src = instr[7:0];
  assign dec_dst = instr[7:0] + 8'h40;
  assign dp_result = opnd_data + 16'h0100;
  assign mem_rdata = mem[mem_addr];

  function automatic logic [15:0] f(input int i);
    return 16'(i * 3 + 7);
  endfunction

  task automatic push(input logic [7:0] a, input logic we, input logic [15:0] d,
                      input logic io, input int gap, input string tag);
    item_t it;
    it.a = a; it.we = we; it.d = d; it.io = io; it.gap = gap; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (mem_req && mem_rdy) wcnt <= 0;
    else if (mem_req) wcnt <= wcnt + 1;
    if (mem_req && mem_we && mem_rdy) mem[mem_addr] <= mem_wdata;
  end

  always @(negedge clk) begin
    item_t e;
    cyc++;
    if (drop_pend) begin irq = 1'b0; drop_pend = 0; end
    mem_rdy = mem_req && (wcnt == int'(mem_addr[1:0]));
    if (mem_rdy && !rst && !done) begin
      if (q.size() == 0) begin
        check(0, "R4", "unexpected request at", int'(mem_addr), 0);
      end else begin
        e = q.pop_front();
        check(mem_addr == e.a && mem_we == e.we && io_sel == e.io, e.tag, "addr/we/io",
              int'({mem_addr, 3'b0, mem_we, 3'b0, io_sel}), int'({e.a, 3'b0, e.we, 3'b0, e.io}));
        if (e.we) check(mem_wdata == e.d, e.tag, "write data", int'(mem_wdata), int'(e.d));
        if (e.gap != 0) check(cyc - last_hs == e.gap, e.tag, "cycle gap", cyc - last_hs, e.gap);
        if (e.a == 8'h0B && !raised) begin irq = 1'b1; raised = 1; end
      end
      last_hs = cyc;
    end
    if (irq_ack && !rst) begin
      acks++;
      if (acks == 2) drop_pend = 1;
    end
  end

  initial begin
    int wd;
    mem_rdy = 1'b0;
    for (int i = 0; i < 256; i++) mem[i] = f(i);
    mem[8'h00] = 16'h3010; mem[8'h01] = 16'hB220; mem[8'h02] = 16'h7030;
    mem[8'h03] = 16'hC008; mem[8'h08] = 16'h0000; mem[8'h09] = 16'h2011;
    mem[8'h0A] = 16'h1012; mem[8'h0B] = 16'hC00B;
    mem[8'hF0] = 16'h3015; mem[8'hF1] = 16'hC800;

    push(8'h00, 0, 0, 0, 0, "R1");
    push(8'h10, 0, 0, 0, 0, "R6");
    push(8'h50, 1, f(8'h10), 0, 2, "R6");
    push(8'h01, 0, 0, 0, 0, "R5");
    push(8'h20, 0, 0, 0, 0, "R7");
    push(8'h60, 1, f(8'h20) + 16'h0100, 0, 3, "R6");
    push(8'h21, 0, 0, 0, 3, "R7");
    push(8'h61, 1, f(8'h21) + 16'h0100, 0, 0, "R7");
    push(8'h22, 0, 0, 0, 0, "R7");
    push(8'h62, 1, f(8'h22) + 16'h0100, 0, 0, "R7");
    push(8'h02, 0, 0, 0, 0, "R4");
    push(8'h30, 0, 0, 1, 0, "R8");
    push(8'h70, 1, f(8'h30), 1, 0, "R8");
    push(8'h03, 0, 0, 0, 0, "R4");
    push(8'h08, 0, 0, 0, 4, "R4");
    push(8'h09, 0, 0, 0, 5, "R3");
    push(8'h11, 0, 0, 0, 0, "R6");
    push(8'h0A, 0, 0, 0, 0, "R4");
    push(8'h52, 1, f(8'h11), 0, 0, "R6");
    push(8'h0B, 0, 0, 0, 0, "R4");
    push(8'hF0, 0, 0, 0, 0, "R9");
    push(8'h15, 0, 0, 0, 0, "R9");
    push(8'h55, 1, f(8'h15), 0, 0, "R9");
    push(8'hF1, 0, 0, 0, 0, "R10");
    push(8'h0B, 0, 0, 0, 0, "R11");
    push(8'hF0, 0, 0, 0, 0, "R10");
    push(8'h15, 0, 0, 0, 0, "R10");
    push(8'h55, 1, f(8'h15), 0, 0, "R10");
    push(8'hF1, 0, 0, 0, 0, "R10");
    push(8'h0B, 0, 0, 0, 0, "R11");
    push(8'h0B, 0, 0, 0, 0, "R11");

    repeat (3) @(negedge clk);
    check(phase == 8'h01 && !mem_req && !irq_ack, "R1", "reset state",
          int'({mem_req, irq_ack, phase}), 1);
    rst = 1'b0;
    wd = 0;
    while (q.size() != 0 && wd < 20000) begin
      @(negedge clk);
      wd++;
    end
    done = 1;
    if (wd >= 20000) check(0, "R3", "watchdog expired, items left", q.size(), 0);
    repeat (4) @(negedge clk);
    check(acks == 2, "R10", "interrupt accept count", acks, 2);
    check(irq == 1'b0, "R9", "request dropped after second accept", int'(irq), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule